// File: doc/BRIEF.md
# Debug Event Privilege Qualifier

This block sits behind the address comparators of a processor's debug unit. Each of N slots (watchpoints or breakpoints, depending on which kind of lookup is being qualified) reports a raw address hit. The block decides which of those raw hits become real debug events. It checks each hit against the slot's own control word and the processor's current context: the security state, the exception level, and an optional link to a context-comparison slot. It then returns whether any slot qualified and which one it was.

A lookup enters on a valid/ready input handshake and leaves one cycle later through a single output register with its own valid/ready handshake. The input handshake may complete while the output register is empty or is being drained in the same cycle. When `out_valid` is high and `out_ready` is low, the held result stays frozen and `in_ready` stays low.

The context comparison for linked slots lives in a separate block. This block raises a one-hot-per-target request vector naming the link targets it needs. The neighbouring comparator answers in the same cycle with a pass vector indexed by link number.

Top module: `dbgq_qualifier`

## Requirements
- R1: Control word layout is: enable bit 0, privilege bits [2:1], higher-mode bit 13, security field [15:14], link number [19:16], link-enable bit 20. A slot whose raw-hit bit is clear, or whose enable bit is 0, never produces an event.
- R2: The security field filters on `in_secure`, the processor's current state. Value 0 passes in both states. Values 1 and 3 pass only when `in_secure` is 0. Value 2 passes only when `in_secure` is 1.
- R3: At effective exception level 2 or 3, a slot passes only if its higher-mode bit (13) is set.
- R4: At effective level 1, a slot passes only if privilege bit 1 of the word (field bit 0) is set. At effective level 0, a slot passes only if word bit 2 (field bit 1) is set.
- R5: When `in_kind_wp` is 1 and `in_unpriv` is 1, the privilege check uses level 0 whatever `in_el` is. When `in_kind_wp` is 0, `in_unpriv` has no effect.
- R6: When the link-enable bit is set, the slot passes only if `lnk_pass[link number]` is 1. While `in_valid` is high, `lnk_req` bit k is set exactly when some raw-hit, enabled, link-enabled slot names target k. While `in_valid` is low, `lnk_req` is all zero.
- R7: For watchpoint lookups (`in_kind_wp`=1), no event is reported when `in_wp_global_en` is 0 or `in_dbg_masked` is 1. Breakpoint lookups ignore both inputs.
- R8: `out_hit` is set when any slot qualifies. `out_slot` gives the lowest qualifying index, and is 0 when no slot qualifies.
- R9: A lookup accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_valid`/`out_hit`/`out_slot` immediately after that edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outputs hold stable and `in_ready` is 0. Otherwise `in_ready` is 1.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Lookup present |
| in_ready | output | 1 | Lookup can be accepted |
| in_kind_wp | input | 1 | 1 = watchpoint lookup, 0 = breakpoint lookup |
| in_raw_hit | input | N | Per-slot raw address hit |
| in_ctrl | input | N*32 | Per-slot control words, slot i at bits [32i+31:32i] |
| in_el | input | 2 | Current exception level |
| in_secure | input | 1 | Current security state of the processor |
| in_unpriv | input | 1 | Access came from an unprivileged load/store instruction |
| in_wp_global_en | input | 1 | Global watchpoint enable |
| in_dbg_masked | input | 1 | Debug exceptions currently masked |
| lnk_req | output | 16 | Link targets whose context check is needed |
| lnk_pass | input | 16 | Per-target context check result |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | At least one slot qualified |
| out_slot | output | clog2(N) | Lowest qualifying slot |

## Verification
Directed lookups walk each security-field value in both security states, so that a swapped state polarity or a mishandled value 3 shows up. Each exception level is paired with control words that set only one of the privilege or higher-mode bits, which separates the level decode paths. Unprivileged accesses are tried on both lookup kinds at level 1 and level 2, telling the watchpoint override apart from a global one. Link targets are driven pass and fail, and the gating inputs are tried on both kinds. Multi-slot hits with competing priorities, a stalled consumer, and a long randomized stretch are compared cycle by cycle against a behavioural model.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;
  localparam int CTRL_W   = 32;
  localparam int LINK_W   = 4;
  localparam int LINK_N   = 1 << LINK_W;

  typedef struct packed {
    logic              en;
    logic [1:0]        pac;
    logic              hmc;
    logic [1:0]        ssc;
    logic [LINK_W-1:0] lbn;
    logic              lk;
  } slot_ctrl_t;

  function automatic slot_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
    slot_ctrl_t c;
    c.en  = w[0];
    c.pac = w[2:1];
    c.hmc = w[13];
    c.ssc = w[15:14];
    c.lbn = w[19:16];
    c.lk  = w[20];
    return c;
  endfunction
endpackage

// File: rtl/dbgq_slot_filter.sv
module dbgq_slot_filter
  import dbgq_pkg::*;
(
  input  logic              raw,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [1:0]        eff_el,
  input  logic              secure,
  input  logic              gate,
  input  logic [LINK_N-1:0] lnk_pass,
  output logic              pass,
  output logic [LINK_N-1:0] req
);
  slot_ctrl_t c;
  logic sec_ok, priv_ok, link_ok, armed;

  always_comb begin
    c = unpack_ctrl(ctrl_word);
    unique case (c.ssc)
      2'd0:    sec_ok = 1'b1;
      2'd2:    sec_ok = secure;
      default: sec_ok = !secure;
    endcase
    unique case (eff_el)
      2'd0:    priv_ok = c.pac[1];
      2'd1:    priv_ok = c.pac[0];
      default: priv_ok = c.hmc;
    endcase
    armed   = raw && c.en;
    link_ok = !c.lk || lnk_pass[c.lbn];
    pass    = armed && gate && sec_ok && priv_ok && link_ok;
    req     = '0;
    if (armed && c.lk) req[c.lbn] = 1'b1;
  end
endmodule

// File: rtl/dbgq_prio_enc.sv
module dbgq_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dbgq_out_stage.sv
module dbgq_out_stage #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             d_hit,
  input  logic [IDX_W-1:0] d_slot,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_slot
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_slot  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_hit   <= d_hit;
      out_slot  <= d_slot;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgq_qualifier.sv
module dbgq_qualifier
  import dbgq_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_kind_wp,
  input  logic [N-1:0]        in_raw_hit,
  input  logic [N*CTRL_W-1:0] in_ctrl,
  input  logic [1:0]          in_el,
  input  logic                in_secure,
  input  logic                in_unpriv,
  input  logic                in_wp_global_en,
  input  logic                in_dbg_masked,
  output logic [LINK_N-1:0]   lnk_req,
  input  logic [LINK_N-1:0]   lnk_pass,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_hit,
  output logic [IDX_W-1:0]    out_slot
);
  logic [1:0]        eff_el;
  logic              gate;
  logic [N-1:0]      pass_vec;
  logic [LINK_N-1:0] req_vec [N];
  logic              any_hit;
  logic [IDX_W-1:0]  first_idx;

  assign eff_el = (in_kind_wp && in_unpriv) ? 2'd0 : in_el;
  assign gate   = !in_kind_wp || (in_wp_global_en && !in_dbg_masked);

  for (genvar i = 0; i < N; i++) begin : g_slot
    dbgq_slot_filter u_filt (
      .raw       (in_raw_hit[i]),
      .ctrl_word (in_ctrl[i*CTRL_W +: CTRL_W]),
      .eff_el    (eff_el),
      .secure    (in_secure),
      .gate      (gate),
      .lnk_pass  (lnk_pass),
      .pass      (pass_vec[i]),
      .req       (req_vec[i])
    );
  end

  always_comb begin
    lnk_req = '0;
    for (int i = 0; i < N; i++) lnk_req = lnk_req | req_vec[i];
    if (!in_valid) lnk_req = '0;
  end

  dbgq_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .req (pass_vec),
    .any (any_hit),
    .idx (first_idx)
  );

  dbgq_out_stage #(.IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_hit     (any_hit),
    .d_slot    (first_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_hit   (out_hit),
    .out_slot  (out_slot)
  );
endmodule

// File: rtl/dbgq_checker.sv
module dbgq_checker
  import dbgq_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_kind_wp,
  input logic [N-1:0]        in_raw_hit,
  input logic                in_wp_global_en,
  input logic                in_dbg_masked,
  input logic [LINK_N-1:0]   lnk_req,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_hit,
  input logic [IDX_W-1:0]    out_slot
);
  logic fire;
  assign fire = in_valid && in_ready;

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_slot)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_noslot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_slot == '0));

  assert_nohit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_raw_hit == '0)) |=> !out_hit);

  assert_wpgate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind_wp && (!in_wp_global_en || in_dbg_masked)) |=> !out_hit);

  assert_lnkidle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (lnk_req == '0));
endmodule

bind dbgq_qualifier dbgq_checker #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_kind_wp      (in_kind_wp),
  .in_raw_hit      (in_raw_hit),
  .in_wp_global_en (in_wp_global_en),
  .in_dbg_masked   (in_dbg_masked),
  .lnk_req         (lnk_req),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_hit         (out_hit),
  .out_slot        (out_slot)
);

// File: tb/dbgq_qualifier_tb.sv
module dbgq_qualifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            in_valid = 0;
  logic            in_ready;
  logic            in_kind_wp = 0;
  logic [N-1:0]    in_raw_hit = '0;
  logic [N*32-1:0] in_ctrl = '0;
  logic [1:0]      in_el = 0;
  logic            in_secure = 0;
  logic            in_unpriv = 0;
  logic            in_wp_global_en = 1;
  logic            in_dbg_masked = 0;
  logic [15:0]     lnk_req;
  logic [15:0]     lnk_pass = '0;
  logic            out_valid;
  logic            out_ready = 1;
  logic            out_hit;
  logic [IW-1:0]   out_slot;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  bit mv = 0, mh = 0;
  int ms = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgq_qualifier #(.N(N)) u_dut (.*);

  function automatic logic [31:0] mk(bit en, bit [1:0] pac, bit hmc, bit [1:0] ssc,
                                     bit [3:0] lbn, bit lk);
    logic [31:0] w = '0;
    w[0] = en; w[2:1] = pac; w[13] = hmc; w[15:14] = ssc; w[19:16] = lbn; w[20] = lk;
    return w;
  endfunction

  task automatic set_slot(int i, logic [31:0] w);
    in_ctrl[i*32 +: 32] = w;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_eval(output bit h, output int s, output logic [15:0] rq);
    h = 0; s = 0; rq = '0;
    for (int i = N - 1; i >= 0; i--) begin
      logic [31:0] w = in_ctrl[i*32 +: 32];
      int lvl = (in_kind_wp && in_unpriv) ? 0 : int'(in_el);
      bit ok = 1;
      if (!in_raw_hit[i] || !w[0]) continue;
      if (w[20]) rq[w[19:16]] = 1'b1;
      if (w[15:14] == 2 && !in_secure) ok = 0;
      if ((w[15:14] == 1 || w[15:14] == 3) && in_secure) ok = 0;
      if (lvl >= 2 && !w[13]) ok = 0;
      if (lvl == 1 && !w[1]) ok = 0;
      if (lvl == 0 && !w[2]) ok = 0;
      if (w[20] && !lnk_pass[w[19:16]]) ok = 0;
      if (in_kind_wp && (!in_wp_global_en || in_dbg_masked)) ok = 0;
      if (ok) begin h = 1; s = i; end
    end
    if (!in_valid) rq = '0;
  endtask

  // called just after a negedge with inputs already set
  task automatic cyc(string tag);
    bit h; int s; logic [15:0] rq; bit fire;
    #1;
    ref_eval(h, s, rq);
    chk({tag, " R10 in_ready"}, int'(in_ready), int'(!mv || out_ready));
    chk({tag, " R6 lnk_req"}, int'(lnk_req), int'(rq));
    fire = in_valid && (!mv || out_ready);
    @(posedge clk);
    if (fire) begin mv = 1; mh = h; ms = s; end
    else if (out_ready) mv = 0;
    @(negedge clk);
    chk({tag, " R9 out_valid"}, int'(out_valid), int'(mv));
    if (mv) begin
      chk({tag, " R8 out_hit"}, int'(out_hit), int'(mh));
      chk({tag, " R8 out_slot"}, int'(out_slot), ms);
    end
  endtask

  task automatic one(string tag, logic [31:0] w0, bit sec, bit [1:0] el);
    in_ctrl = '0; set_slot(0, w0); in_raw_hit = 8'h01;
    in_secure = sec; in_el = el; in_valid = 1;
    cyc(tag);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 out_valid in reset", int'(out_valid), 0);
    chk("R11 in_ready in reset", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R11 out_valid after reset", int'(out_valid), 0);

    // R1: raw clear / enable clear
    in_valid = 1; in_ctrl = '0; set_slot(0, mk(1, 2'b11, 1, 0, 0, 0)); in_raw_hit = 0;
    cyc("R1 raw clear");
    one("R1 enable clear", mk(0, 2'b11, 1, 0, 0, 0), 0, 1);
    one("R1 enabled", mk(1, 2'b11, 1, 0, 0, 0), 0, 1);

    // R2: security field
    for (int ssc = 0; ssc < 4; ssc++)
      for (int sec = 0; sec < 2; sec++)
        one("R2 ssc", mk(1, 2'b11, 1, 2'(ssc), 0, 0), 1'(sec), 1);

    // R3/R4: privilege decode, one qualifying bit at a time
    for (int el = 0; el < 4; el++) begin
      one("R3 R4 pac0", mk(1, 2'b01, 0, 0, 0, 0), 0, 2'(el));
      one("R3 R4 pac1", mk(1, 2'b10, 0, 0, 0, 0), 0, 2'(el));
      one("R3 hmc", mk(1, 2'b00, 1, 0, 0, 0), 0, 2'(el));
    end

    // R5: unprivileged access
    for (int k = 0; k < 2; k++) begin
      in_kind_wp = 1'(k); in_unpriv = 1;
      one("R5 unpriv el1 pac1", mk(1, 2'b10, 0, 0, 0, 0), 0, 1);
      one("R5 unpriv el2 pac1", mk(1, 2'b10, 0, 0, 0, 0), 0, 2);
      one("R5 unpriv el2 hmc", mk(1, 2'b00, 1, 0, 0, 0), 0, 2);
    end
    in_unpriv = 0;

    // R7: watch gating, breakpoints unaffected
    for (int k = 0; k < 2; k++) begin
      in_kind_wp = 1'(k);
      in_wp_global_en = 0; in_dbg_masked = 0;
      one("R7 global off", mk(1, 2'b11, 1, 0, 0, 0), 0, 1);
      in_wp_global_en = 1; in_dbg_masked = 1;
      one("R7 masked", mk(1, 2'b11, 1, 0, 0, 0), 0, 1);
      in_dbg_masked = 0;
      one("R7 open", mk(1, 2'b11, 1, 0, 0, 0), 0, 1);
    end
    in_kind_wp = 0;

    // R6: link check
    lnk_pass = 16'h0000;
    one("R6 link fail", mk(1, 2'b11, 1, 0, 4'd9, 1), 0, 1);
    lnk_pass = 16'h0200;
    one("R6 link pass", mk(1, 2'b11, 1, 0, 4'd9, 1), 0, 1);
    lnk_pass = 16'hFDFF;
    one("R6 other target", mk(1, 2'b11, 1, 0, 4'd9, 1), 0, 1);

    // R8: priority
    in_ctrl = '0;
    for (int i = 0; i < N; i++) set_slot(i, mk(1, 2'b11, 1, 0, 0, 0));
    set_slot(1, mk(1, 2'b11, 1, 2, 0, 0));
    in_raw_hit = 8'b1010_0110; in_secure = 0; in_el = 1;
    cyc("R8 lowest passing");
    in_raw_hit = 8'b1000_0000;
    cyc("R8 top slot");
    in_raw_hit = 8'b0000_0010;
    cyc("R8 none");

    // R10: back-pressure
    out_ready = 0; in_raw_hit = 8'b0001_0000;
    cyc("R10 load");
    in_raw_hit = 8'b0000_0001;
    for (int k = 0; k < 3; k++) cyc("R10 hold");
    out_ready = 1;
    cyc("R10 release");
    in_valid = 0;
    cyc("R10 drain");
    cyc("R9 idle");

    // random stretch
    for (int k = 0; k < 400; k++) begin
      in_valid = 1'($urandom_range(0, 3) != 0);
      out_ready = 1'($urandom_range(0, 3) != 0);
      in_kind_wp = 1'($urandom); in_unpriv = 1'($urandom);
      in_el = 2'($urandom); in_secure = 1'($urandom);
      in_wp_global_en = 1'($urandom_range(0, 5) != 0);
      in_dbg_masked = 1'($urandom_range(0, 5) == 0);
      in_raw_hit = N'($urandom);
      lnk_pass = 16'($urandom);
      for (int i = 0; i < N; i++) set_slot(i, 32'($urandom) | 32'h1);
      cyc("R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule